// File: doc/BRIEF.md
# SDRAM Column Read Burst Pipeline

This block is the device-side read path of a synchronous DRAM, from the point where a READ command is accepted to the point where data leaves on the bus. A READ names a bank, a starting column and whether the row should be closed automatically afterwards. The block then walks the column address once per clock for the programmed burst length. It fetches each word through a simple combinational array-read port and presents the words on a tri-state data bus after the programmed CAS latency of two or three clocks.

A new READ may be given on any cycle. It cuts the burst in flight short, and its own words follow the last wanted word of the old burst with no idle cycle between them. Fixed bursts of 1, 2, 4 or 8 words wrap inside their aligned column block. A full-page burst wraps around the page and runs until another READ replaces it. When a fixed burst with automatic precharge runs to its end, a precharge request for that bank is raised while its last word is on the bus.

Top module: `sdr_rdburst_top`

## Requirements
- R1: With `cfg_cl` = 0 the first word is driven after the 2nd rising edge following the edge that samples the READ; with `cfg_cl` = 1 it is driven after the 3rd. That first word is the array word at (`cmd_bank`, `cmd_col`).
- R2: Burst code `cfg_bl` (sampled with the READ) 0, 1, 2 and 3 gives 1, 2, 4 and 8 words, one per cycle. Word j reads column (start with its low log2(len) bits cleared) OR ((start + j) mod len).
- R3: `cfg_bl` codes 4 to 7 select a full-page burst: word j reads column (start + j) mod 512, and the burst never stops by itself.
- R4: A READ is accepted on any cycle, including one where a burst is in flight. Its first word appears per R1 and replaces every remaining word of the older burst, so a READ given CL-1 cycles before the edge of old word k makes k the last old word with no gap after it.
- R5: A READ given exactly len cycles after a fixed burst's READ makes its data follow the old burst's last word with no idle cycle.
- R6: When a burst ends and no later READ has taken effect, `dq_oe` is low and `dq` is released to high impedance.
- R7: `pre_req` is high, with `pre_bank` equal to the burst's bank, during exactly the cycle that the last word of a fixed burst issued with `cmd_ap` = 1 is driven. It stays low for bursts with `cmd_ap` = 0, for bursts that a later READ cut short, and for full-page bursts.
- R8: Synchronous active-high `rst` discards every pending word. From the edge that samples `rst`, `dq_oe` and `pre_req` stay low until a new READ delivers data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd | input | 1 | READ command strobe |
| cmd_bank | input | 2 | Bank of the READ |
| cmd_col | input | 9 | Starting column of the READ |
| cmd_ap | input | 1 | Close the row when the burst completes |
| cfg_cl | input | 1 | CAS latency: 0 = 2 clocks, 1 = 3 clocks |
| cfg_bl | input | 3 | Burst code: 0..3 = 1/2/4/8 words, 4..7 = full page |
| arr_rd_en | output | 1 | Array read strobe for the current burst word |
| arr_bank | output | 2 | Bank of the array read |
| arr_col | output | 9 | Column of the array read |
| arr_data | input | 16 | Array read data, valid in the same cycle |
| dq | inout | 16 | Data-out bus, high impedance when idle |
| dq_oe | output | 1 | High while `dq` is driven |
| pre_req | output | 1 | Precharge request for the completed burst's bank |
| pre_bank | output | 2 | Bank to precharge |

## Verification
On every cycle, the assertions check the address engine's own invariants. These are that the beat counter stays inside the burst length, that a fixed burst never leaves its aligned column block, that a full-page burst steps from column 511 to 0, that a READ always restarts the engine, and that reset empties the latency stages. What only the bench's scenarios can show is the end-to-end timing at the ports. That covers the exact edge of the first word for each latency, the seamless hand-over when a READ truncates or follows a burst, the release of the bus after a burst, and whether a precharge request appears or is suppressed.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
    localparam int DQ_W   = 16;
    localparam int COL_W  = 9;
    localparam int BANK_W = 2;
    localparam int BLC_W  = 3;
    localparam int CNT_W  = 4;
    localparam int MAX_CL = 3;
    localparam int PAGE   = 1 << COL_W;

    typedef struct packed {
        logic              vld;
        logic              ap_last;
        logic [BANK_W-1:0] bank;
        logic [DQ_W-1:0]   data;
    } rd_beat_t;

    // Codes with the top bit set select a full-page burst.
    function automatic logic is_page(input logic [BLC_W-1:0] code);
        return code[BLC_W-1];
    endfunction

    // Word count minus one for the fixed lengths 1, 2, 4, 8.
    function automatic logic [CNT_W-1:0] blk_mask(input logic [BLC_W-1:0] code);
        case (code[1:0])
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(1);
            2'd2:    return CNT_W'(3);
            default: return CNT_W'(7);
        endcase
    endfunction

    function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] col,
                                                  input logic [BLC_W-1:0] code);
        logic [COL_W-1:0] m;
        m = COL_W'(blk_mask(code));
        if (is_page(code))
            return col + 1'b1;
        return (col & ~m) | ((col + 1'b1) & m);
    endfunction
endpackage

// File: rtl/sdr_rd_addr_eng.sv
module sdr_rd_addr_eng
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_rd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [BLC_W-1:0]  cfg_bl,
    output logic              iss_vld,
    output logic              iss_ap_last,
    output logic [BANK_W-1:0] iss_bank,
    output logic [COL_W-1:0]  iss_col
);
    logic              active;
    logic              ap_q;
    logic [BLC_W-1:0]  blc;
    logic [CNT_W-1:0]  cnt;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              last;

    assign last = active && !is_page(blc) && (cnt == blk_mask(blc));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ap_q   <= 1'b0;
            blc    <= '0;
            cnt    <= '0;
            bank_q <= '0;
            col_q  <= '0;
        end else if (cmd_rd) begin
            active <= 1'b1;
            ap_q   <= cmd_ap;
            blc    <= cfg_bl;
            cnt    <= '0;
            bank_q <= cmd_bank;
            col_q  <= cmd_col;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                col_q <= step_col(col_q, blc);
                if (!is_page(blc))
                    cnt <= cnt + 1'b1;
            end
        end
    end

    assign iss_vld     = active;
    assign iss_ap_last = last && ap_q;
    assign iss_bank    = bank_q;
    assign iss_col     = col_q;

    // R4: a READ always restarts the engine at beat zero
    p_cmd_restart_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> (active && cnt == '0));
    // R2: beat counter never passes the fixed length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (active && !is_page(blc)) |-> (cnt <= blk_mask(blc)));
    // R2: a fixed burst stays inside its aligned column block
    p_block_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (active && !is_page(blc) && !cmd_rd && !last)
        |=> ((col_q >> 3) == $past(col_q >> 3)));
    // R3: full page wraps from the last column to column zero
    p_page_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (active && is_page(blc) && !cmd_rd && col_q == COL_W'(PAGE-1))
        |=> (col_q == '0));
    // R6: a completed burst leaves the engine idle
    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (last && !cmd_rd) |=> !active);
endmodule

// File: rtl/sdr_rd_lat_pipe.sv
module sdr_rd_lat_pipe
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cl,
    input  logic              iss_vld,
    input  logic              iss_ap_last,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [DQ_W-1:0]   arr_data,
    output rd_beat_t          beat_out
);
    rd_beat_t st [MAX_CL];

    always_ff @(posedge clk) begin
        if (rst) begin
            st[0] <= '0;
        end else begin
            st[0].vld     <= iss_vld;
            st[0].ap_last <= iss_ap_last;
            st[0].bank    <= iss_bank;
            st[0].data    <= arr_data;
        end
    end

    for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= '0;
            else     st[i] <= st[i-1];
        end
    end

    // Latency 3 taps the last stage, latency 2 the one before it.
    assign beat_out = cfg_cl ? st[MAX_CL-1] : st[MAX_CL-2];

    // R8: reset empties the first and last latency stages
    p_rst_clear_r8: assert property (@(posedge clk)
        rst |=> (!st[0].vld && !st[MAX_CL-1].vld));
    // R2: every captured beat advances one stage per clock
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        st[0].vld |=> st[1].vld);
endmodule

// File: rtl/sdr_rd_dq_drv.sv
module sdr_rd_dq_drv
    import sdr_rd_pkg::*;
(
    input  rd_beat_t          beat,
    inout  wire  [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    assign dq       = beat.vld ? beat.data : {DQ_W{1'bz}};
    assign dq_oe    = beat.vld;
    assign pre_req  = beat.vld && beat.ap_last;
    assign pre_bank = beat.bank;
endmodule

// File: rtl/sdr_rdburst_top.sv
module sdr_rdburst_top
    import sdr_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_rd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic              cfg_cl,
    input  logic [BLC_W-1:0]  cfg_bl,
    output logic              arr_rd_en,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col,
    input  logic [DQ_W-1:0]   arr_data,
    inout  wire  [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    logic     iss_ap_last;
    rd_beat_t beat;

    sdr_rd_addr_eng u_eng (
        .clk        (clk),
        .rst        (rst),
        .cmd_rd     (cmd_rd),
        .cmd_bank   (cmd_bank),
        .cmd_col    (cmd_col),
        .cmd_ap     (cmd_ap),
        .cfg_bl     (cfg_bl),
        .iss_vld    (arr_rd_en),
        .iss_ap_last(iss_ap_last),
        .iss_bank   (arr_bank),
        .iss_col    (arr_col)
    );

    sdr_rd_lat_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .cfg_cl     (cfg_cl),
        .iss_vld    (arr_rd_en),
        .iss_ap_last(iss_ap_last),
        .iss_bank   (arr_bank),
        .arr_data   (arr_data),
        .beat_out   (beat)
    );

    sdr_rd_dq_drv u_drv (
        .beat    (beat),
        .dq      (dq),
        .dq_oe   (dq_oe),
        .pre_req (pre_req),
        .pre_bank(pre_bank)
    );
endmodule

// File: tb/sdr_rdburst_top_tb.sv
`timescale 1ns/1ps
module sdr_rdburst_top_tb;
    localparam int HZ = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_rd = 1'b0;
    logic [1:0]  cmd_bank = '0;
    logic [8:0]  cmd_col = '0;
    logic        cmd_ap = 1'b0;
    logic        cfg_cl = 1'b0;
    logic [2:0]  cfg_bl = '0;
    logic        arr_rd_en;
    logic [1:0]  arr_bank;
    logic [8:0]  arr_col;
    logic [15:0] arr_data;
    wire  [15:0] dq;
    logic        dq_oe, pre_req;
    logic [1:0]  pre_bank;

    int checks = 0;
    int errors = 0;
    int lat = 2;

    always #2 clk = ~clk;

    sdr_rdburst_top u_dut (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
        .arr_rd_en(arr_rd_en), .arr_bank(arr_bank), .arr_col(arr_col),
        .arr_data(arr_data), .dq(dq), .dq_oe(dq_oe), .pre_req(pre_req),
        .pre_bank(pre_bank)
    );

    function automatic logic [15:0] mk_data(input logic [1:0] b, input logic [8:0] c);
        return {b, 5'h15, c};
    endfunction

    assign arr_data = mk_data(arr_bank, arr_col);

    // expected output per cycle, and stimulus per cycle
    logic        pv [HZ];
    logic [15:0] pd [HZ];
    logic        pp [HZ];
    logic [1:0]  pb [HZ];
    logic        s_rst [HZ];
    logic        s_rd  [HZ];
    logic [1:0]  s_bank[HZ];
    logic [8:0]  s_col [HZ];
    logic        s_ap  [HZ];
    logic [2:0]  s_bl  [HZ];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < HZ; i++) begin
            pv[i] = 0; pd[i] = '0; pp[i] = 0; pb[i] = '0;
            s_rst[i] = (i == 0); s_rd[i] = 0; s_bank[i] = '0;
            s_col[i] = '0; s_ap[i] = 0; s_bl[i] = '0;
        end
    endtask

    task automatic add_read(input int t, input logic [2:0] bl, input logic [1:0] bank,
                            input logic [8:0] col, input logic ap);
        int st, n, mask;
        logic [8:0] cj;
        s_rd[t] = 1; s_bank[t] = bank; s_col[t] = col; s_ap[t] = ap; s_bl[t] = bl;
        st = t + lat;
        for (int s = st; s < HZ; s++) begin pv[s] = 0; pp[s] = 0; end
        n = bl[2] ? HZ : (1 << bl[1:0]);
        mask = n - 1;
        for (int j = 0; j < n && st + j < HZ; j++) begin
            if (bl[2]) cj = 9'((int'(col) + j) % 512);
            else       cj = 9'((int'(col) & ~mask) | ((int'(col) + j) & mask));
            pv[st+j] = 1;
            pd[st+j] = mk_data(bank, cj);
            if (!bl[2] && ap && j == n - 1) begin pp[st+j] = 1; pb[st+j] = bank; end
        end
    endtask

    task automatic add_reset(input int t);
        s_rst[t] = 1;
        for (int s = t; s < HZ; s++) begin pv[s] = 0; pp[s] = 0; end
    endtask

    // Drive at negedge, pass one rising edge, compare at the next negedge.
    task automatic run(input int ncyc, input string tag, output int oe_cnt);
        oe_cnt = 0;
        for (int c = 0; c < ncyc; c++) begin
            rst = s_rst[c]; cmd_rd = s_rd[c]; cmd_bank = s_bank[c];
            cmd_col = s_col[c]; cmd_ap = s_ap[c]; cfg_bl = s_bl[c];
            @(negedge clk);
            if (dq_oe) oe_cnt++;
            chk(dq_oe == pv[c], tag, $sformatf("dq_oe cyc%0d", c), 32'(dq_oe), 32'(pv[c]));
            if (pv[c] && dq_oe)
                chk(dq == pd[c], tag, $sformatf("dq cyc%0d", c), 32'(dq), 32'(pd[c]));
            chk(pre_req == pp[c], tag, $sformatf("pre_req cyc%0d", c), 32'(pre_req), 32'(pp[c]));
            if (pp[c] && pre_req)
                chk(pre_bank == pb[c], tag, $sformatf("pre_bank cyc%0d", c),
                    32'(pre_bank), 32'(pb[c]));
        end
        rst = 1'b0; cmd_rd = 1'b0;
    endtask

    typedef struct packed {
        logic       cl;
        logic [2:0] bl;
        logic [1:0] bank;
        logic [8:0] col;
        logic       ap;
        logic [7:0] exp_n;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 3'd0, 2'd0, 9'd5,   1'b0, 8'd1},
        '{1'b1, 3'd1, 2'd1, 9'd7,   1'b0, 8'd2},
        '{1'b0, 3'd2, 2'd2, 9'd6,   1'b1, 8'd4},
        '{1'b1, 3'd3, 2'd3, 9'd13,  1'b1, 8'd8},
        '{1'b1, 3'd2, 2'd0, 9'd0,   1'b0, 8'd4},
        '{1'b0, 3'd7, 2'd1, 9'd509, 1'b0, 8'd21},
        '{1'b1, 3'd4, 2'd2, 9'd3,   1'b1, 8'd20},
        '{1'b0, 3'd3, 2'd3, 9'd511, 1'b1, 8'd8}
    };

    task automatic set_cl(input logic c);
        cfg_cl = c;
        lat = c ? 3 : 2;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        @(negedge clk);

        // R8: reset state
        clear_all();
        run(2, "R8 reset", n);
        chk(dq_oe == 1'b0 && pre_req == 1'b0, "R8", "idle after reset",
            32'({dq_oe, pre_req}), 32'(0));

        // Table of single bursts: R1 R2 R3 R6 R7
        foreach (VEC[i]) begin
            set_cl(VEC[i].cl);
            clear_all();
            add_read(1, VEC[i].bl, VEC[i].bank, VEC[i].col, VEC[i].ap);
            run(24, $sformatf("R1/R2/R3/R6/R7 vec%0d", i), n);
            chk(n == int'(VEC[i].exp_n), "R2/R3", $sformatf("word count vec%0d", i),
                32'(n), 32'(VEC[i].exp_n));
        end

        // R4 + R7: truncation after old word 2, CL3; old burst had ap but is cut
        set_cl(1'b1);
        clear_all();
        add_read(1, 3'd3, 2'd0, 9'd0, 1'b1);
        add_read(4, 3'd2, 2'd1, 9'd40, 1'b1);
        run(16, "R4 R7 truncate", n);
        chk(n == 7, "R4", "seamless truncate count", 32'(n), 32'(7));

        // R4: back-to-back single reads every cycle, CL2
        set_cl(1'b0);
        clear_all();
        for (int t = 1; t <= 4; t++) add_read(t, 3'd0, 2'(t - 1), 9'(10 * t), 1'b0);
        run(10, "R4 back-to-back", n);
        chk(n == 4, "R4", "back-to-back count", 32'(n), 32'(4));

        // R5: fixed burst followed with no gap, CL2
        clear_all();
        add_read(1, 3'd2, 2'd2, 9'd20, 1'b0);
        add_read(5, 3'd1, 2'd3, 9'd33, 1'b1);
        run(12, "R5 R7 continuous", n);
        chk(n == 6, "R5", "continuous count", 32'(n), 32'(6));

        // R3 + R4 + R6: full page across the wrap, ended by a single read, CL3
        set_cl(1'b1);
        clear_all();
        add_read(1, 3'd7, 2'd1, 9'd510, 1'b0);
        add_read(7, 3'd0, 2'd2, 9'd100, 1'b0);
        run(16, "R3 R4 R6 page end", n);
        chk(n == 7, "R3", "page burst count", 32'(n), 32'(7));

        // R8: reset in the middle of a burst with ap, CL2
        set_cl(1'b0);
        clear_all();
        add_read(1, 3'd3, 2'd0, 9'd0, 1'b1);
        add_reset(5);
        run(16, "R8 mid-burst reset", n);
        chk(n == 2, "R8", "words before reset", 32'(n), 32'(2));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule